// File: doc/BRIEF.md
# Receiver Power Sequencer

This block steps an external radio receiver through four power stages: off, warm-up, on and shut-down. Each stage has its own pattern for eight control lines, its own duration counted in 625 µs timebase ticks, and a flag that asks for the low-battery pin to be sampled when the stage ends. A host writes the stage settings as four-byte packets on a byte bus with a valid strobe. The decoding logic raises a decoder-on flag to start the sequence and pulses an advance request to leave the on stage.

The control lines stay undriven after reset. The host can release them with a packet, or the first rise of the decoder-on flag releases them. This leaves board pull resistors in charge until the settings are valid. While decoding runs, the stored settings are locked. Each battery poll compares the sampled level with the level from the previous poll. Only a change produces a one-cycle status event that carries the new level.

Top module: `rxseq_top`

## Requirements
- R1: After reset `ctl_oe` is all zeros (lines undriven) and `ctl_line` is 00h; `ctl_oe` bits always switch together.
- R2: After reset every stage has pattern 00h, step count 01h and polling disabled.
- R3: A packet is four bytes: an identifier, a flag byte (bit 0 = poll enable, or release for identifier 14h), a pattern byte and a step byte. Identifiers 10h, 11h, 12h and 13h load the off, warm-up, on and shut-down stages. Any other identifier is dropped without effect.
- R4: A timed stage (off, warm-up, shut-down) lasts its step count in ticks. A step count of 00h acts as 01h.
- R5: With decoding on, the stages run in the order off, warm-up, on, shut-down, off. The on stage ignores ticks and is left only on `adv_req`.
- R6: `ctl_line` shows the new stage's pattern in the cycle after the edge at which the advancing tick or request is sampled.
- R7: When a stage with polling enabled ends, `lobat` (1 = low) is sampled at that edge. `stat_valid` pulses for one cycle with `stat_lobat` equal to the sample only if it differs from the previous poll. The poll history starts at 0 (battery OK).
- R8: Once released, the lines stay driven until reset. Release happens when identifier 14h arrives with flag bit 0 set, or when `dec_on` is first high.
- R9: A packet that completes while `dec_on` is high changes no stored setting.
- R10: While `dec_on` is low, the block sits in the off stage, drives the off pattern and produces no status events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_byte | input | 8 | Packet byte from host |
| pkt_valid | input | 1 | Byte strobe, one byte per cycle |
| tick | input | 1 | Single-cycle 625 µs timebase pulse |
| adv_req | input | 1 | Request to leave the on stage |
| lobat | input | 1 | Low-battery pin, 1 = low |
| dec_on | input | 1 | Decoding enabled |
| ctl_line | output | 8 | Receiver control line values |
| ctl_oe | output | 8 | Per-line output enable |
| stat_valid | output | 1 | Battery status event |
| stat_lobat | output | 1 | Battery level carried by the event |

## Verification
The bench targets the stage-duration edges. A two-tick off stage must still show the off pattern after one tick. A zero step count must act as one tick; a design that loaded zero would wrap its counter and stall for 256 ticks. The bench pulses ticks during the on stage; a design that timed out the on stage would move to shut-down early. It sends a packet while decoding runs and later measures the off duration to prove the lock held. On the battery side, it repeats a poll at an unchanged level, which must stay silent, and runs the default settings with the battery low, where a design that polled by default would raise events the scoreboard never expected.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  localparam int NSTAGE = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WARM = 2'd1,
    ST_ON   = 2'd2,
    ST_SHUT = 2'd3
  } rx_stage_e;

  // Stage n is loaded by identifier ID_STAGE0 + n; line release has its own code.
  localparam logic [BYTE_W-1:0] ID_STAGE0  = 8'h10;
  localparam logic [BYTE_W-1:0] ID_RELEASE = 8'h14;

endpackage

// File: rtl/rxseq_cfg.sv
module rxseq_cfg
  import rxseq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int STEP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BYTE_W-1:0]             pkt_byte,
  input  logic                          pkt_valid,
  input  logic                          dec_on,
  output logic [NSTAGE-1:0][LINES-1:0]  pat,
  output logic [NSTAGE-1:0][STEP_W-1:0] step,
  output logic [NSTAGE-1:0]             poll_en,
  output logic                          rel_req
);

  localparam int PKT_LEN = 4;
  localparam int IDX_W   = $clog2(PKT_LEN);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] id_q;
  logic              flag_q;
  logic [BYTE_W-1:0] pat_q;
  logic              commit;

  // Byte position counter and capture of the leading bytes.
  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      id_q   <= '0;
      flag_q <= 1'b0;
      pat_q  <= '0;
    end else if (pkt_valid) begin
      idx <= idx + 1'b1;
      case (idx)
        IDX_W'(0): id_q   <= pkt_byte;
        IDX_W'(1): flag_q <= pkt_byte[0];
        IDX_W'(2): pat_q  <= pkt_byte;
        default: ;
      endcase
    end
  end

  // Last byte completes the packet; settings are locked while decoding runs.
  assign commit  = pkt_valid && (idx == IDX_W'(PKT_LEN - 1)) && !dec_on;
  assign rel_req = commit && (id_q == ID_RELEASE) && flag_q;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        pat[s]     <= '0;
        step[s]    <= STEP_W'(1);
        poll_en[s] <= 1'b0;
      end else if (commit && id_q == (ID_STAGE0 + BYTE_W'(s))) begin
        pat[s]     <= pat_q[LINES-1:0];
        step[s]    <= pkt_byte[STEP_W-1:0];
        poll_en[s] <= flag_q;
      end
    end
  end

endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
  import rxseq_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dec_on,
  input  logic                          tick,
  input  logic                          adv_req,
  input  logic [NSTAGE-1:0][STEP_W-1:0] step,
  output rx_stage_e                     stage,
  output rx_stage_e                     stage_nx,
  output logic                          leave
);

  logic [STEP_W-1:0] cnt;

  function automatic logic [STEP_W-1:0] eff_step(input logic [STEP_W-1:0] s);
    return (s == '0) ? STEP_W'(1) : s;
  endfunction

  always_comb begin
    leave    = 1'b0;
    stage_nx = stage;
    if (!dec_on) begin
      stage_nx = ST_OFF;
    end else begin
      if (stage == ST_ON) leave = adv_req;
      else                leave = tick && (cnt <= STEP_W'(1));
      if (leave) stage_nx = rx_stage_e'(stage + 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_OFF;
      cnt   <= STEP_W'(1);
    end else begin
      stage <= stage_nx;
      if (!dec_on)                      cnt <= eff_step(step[ST_OFF]);
      else if (leave)                   cnt <= eff_step(step[stage_nx]);
      else if (tick && stage != ST_ON)  cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rxseq_batmon.sv
module rxseq_batmon (
  input  logic clk,
  input  logic rst,
  input  logic poll,
  input  logic lobat,
  output logic stat_valid,
  output logic stat_lobat
);

  logic hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist       <= 1'b0;
      stat_valid <= 1'b0;
      stat_lobat <= 1'b0;
    end else begin
      stat_valid <= poll && (lobat != hist);
      if (poll) begin
        hist       <= lobat;
        stat_lobat <= lobat;
      end
    end
  end

endmodule

// File: rtl/rxseq_top.sv
module rxseq_top
  import rxseq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int STEP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       pkt_byte,
  input  logic             pkt_valid,
  input  logic             tick,
  input  logic             adv_req,
  input  logic             lobat,
  input  logic             dec_on,
  output logic [LINES-1:0] ctl_line,
  output logic [LINES-1:0] ctl_oe,
  output logic             stat_valid,
  output logic             stat_lobat
);

  logic [NSTAGE-1:0][LINES-1:0]  pat;
  logic [NSTAGE-1:0][STEP_W-1:0] step;
  logic [NSTAGE-1:0]             poll_en;
  logic                          rel_req;
  rx_stage_e                     stage;
  rx_stage_e                     stage_nx;
  logic                          leave;
  logic                          released;

  rxseq_cfg #(.LINES(LINES), .STEP_W(STEP_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .pkt_byte  (pkt_byte),
    .pkt_valid (pkt_valid),
    .dec_on    (dec_on),
    .pat       (pat),
    .step      (step),
    .poll_en   (poll_en),
    .rel_req   (rel_req)
  );

  rxseq_fsm #(.STEP_W(STEP_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .dec_on   (dec_on),
    .tick     (tick),
    .adv_req  (adv_req),
    .step     (step),
    .stage    (stage),
    .stage_nx (stage_nx),
    .leave    (leave)
  );

  rxseq_batmon u_bat (
    .clk        (clk),
    .rst        (rst),
    .poll       (leave && poll_en[stage]),
    .lobat      (lobat),
    .stat_valid (stat_valid),
    .stat_lobat (stat_lobat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_line <= '0;
      released <= 1'b0;
    end else begin
      ctl_line <= pat[stage_nx];
      if (rel_req || dec_on) released <= 1'b1;
    end
  end

  assign ctl_oe = {LINES{released}};

endmodule

// File: rtl/rxseq_chk.sv
module rxseq_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid,
  input logic             tick,
  input logic             adv_req,
  input logic             lobat,
  input logic             dec_on,
  input logic [LINES-1:0] ctl_line,
  input logic [LINES-1:0] ctl_oe,
  input logic             stat_valid,
  input logic             stat_lobat
);

  a_r1_oe_together: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe == '0) || (ctl_oe == '1));

  a_r8_oe_sticky: assert property (@(posedge clk) disable iff (rst)
    ctl_oe[0] |=> ctl_oe[0]);

  a_r8_first_on: assert property (@(posedge clk) disable iff (rst)
    dec_on |=> ctl_oe[0]);

  a_r7_event_level: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (stat_lobat == $past(lobat)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !dec_on |=> !stat_valid);

  a_r5_lines_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !adv_req && !pkt_valid && !$past(pkt_valid) && dec_on == $past(dec_on))
      |=> $stable(ctl_line));

endmodule

bind rxseq_top rxseq_chk #(.LINES(LINES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pkt_valid  (pkt_valid),
  .tick       (tick),
  .adv_req    (adv_req),
  .lobat      (lobat),
  .dec_on     (dec_on),
  .ctl_line   (ctl_line),
  .ctl_oe     (ctl_oe),
  .stat_valid (stat_valid),
  .stat_lobat (stat_lobat)
);

// File: tb/rxseq_top_test.sv
`timescale 1ns/1ps
module rxseq_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pkt_byte = '0;
  logic       pkt_valid = 1'b0;
  logic       tick = 1'b0;
  logic       adv_req = 1'b0;
  logic       lobat = 1'b0;
  logic       dec_on = 1'b0;
  logic [7:0] ctl_line;
  logic [7:0] ctl_oe;
  logic       stat_valid;
  logic       stat_lobat;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic exp_q[$];

  always #2.5 clk = ~clk;

  rxseq_top uut (
    .clk(clk), .rst(rst), .pkt_byte(pkt_byte), .pkt_valid(pkt_valid),
    .tick(tick), .adv_req(adv_req), .lobat(lobat), .dec_on(dec_on),
    .ctl_line(ctl_line), .ctl_oe(ctl_oe),
    .stat_valid(stat_valid), .stat_lobat(stat_lobat)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] bytes [4];
    bytes = '{b0, b1, b2, b3};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pkt_valid = 1'b1; pkt_byte = bytes[i];
    end
    @(negedge clk); pkt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; dec_on = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Scoreboard monitor: every status event must match the head of the queue (R7).
  always @(negedge clk) begin
    if (!rst && stat_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected event actual %b expected none", stat_lobat);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (stat_lobat !== e) begin
          errors++;
          $display("FAIL R7 event level actual %b expected %b", stat_lobat, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 oe after reset", ctl_oe, 8'h00);
    chk("R1 lines after reset", ctl_line, 8'h00);

    send(8'h10, 8'h01, 8'hA5, 8'h02);
    send(8'h11, 8'h00, 8'h3C, 8'h01);
    send(8'h12, 8'h01, 8'hF0, 8'h05);
    send(8'h13, 8'h00, 8'h0F, 8'h00);
    chk("R10 off pattern while idle", ctl_line, 8'hA5);
    chk("R8 config does not release", ctl_oe, 8'h00);

    send(8'h1F, 8'h01, 8'h55, 8'h01);
    chk("R3 unknown id dropped", ctl_line, 8'hA5);
    send(8'h14, 8'h00, 8'h00, 8'h00);
    chk("R8 release bit clear", ctl_oe, 8'h00);

    lobat = 1'b1;
    @(negedge clk); dec_on = 1'b1;
    @(negedge clk);
    chk("R8 first decode releases", ctl_oe, 8'hFF);

    pulse_tick();
    chk("R4 off lasts two ticks", ctl_line, 8'hA5);
    exp_q.push_back(1'b1);
    pulse_tick();
    chk("R6 warm pattern", ctl_line, 8'h3C);
    pulse_tick();
    chk("R5 on follows warm", ctl_line, 8'hF0);
    repeat (10) pulse_tick();
    chk("R5 on ignores ticks", ctl_line, 8'hF0);

    send(8'h10, 8'h01, 8'h00, 8'h03);
    chk("R9 locked packet", ctl_line, 8'hF0);

    @(negedge clk); adv_req = 1'b1;
    @(negedge clk); adv_req = 1'b0;
    chk("R5 advance to shut-down", ctl_line, 8'h0F);
    pulse_tick();
    chk("R4 zero step acts as one", ctl_line, 8'hA5);

    lobat = 1'b0;
    pulse_tick();
    chk("R9 off step unchanged", ctl_line, 8'hA5);
    exp_q.push_back(1'b0);
    pulse_tick();
    chk("R7 poll on change", ctl_line, 8'h3C);

    @(negedge clk); dec_on = 1'b0;
    @(negedge clk);
    chk("R10 back to off", ctl_line, 8'hA5);
    chk("R8 release sticky", ctl_oe, 8'hFF);

    @(negedge clk); dec_on = 1'b1;
    pulse_tick();
    pulse_tick();
    chk("R7 unchanged level silent", ctl_line, 8'h3C);
    repeat (3) @(negedge clk);
    chk("R7 events delivered", 8'(exp_q.size()), 8'h00);

    do_reset();
    chk("R1 oe after second reset", ctl_oe, 8'h00);
    send(8'h11, 8'h00, 8'h3C, 8'h01);
    send(8'h14, 8'h01, 8'h00, 8'h00);
    chk("R8 release packet", ctl_oe, 8'hFF);
    lobat = 1'b1;
    @(negedge clk); dec_on = 1'b1;
    pulse_tick();
    chk("R2 default off step one", ctl_line, 8'h3C);
    repeat (4) pulse_tick();
    repeat (3) @(negedge clk);
    chk("R2 default no poll", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule